// File: doc/BRIEF.md
# Serial Shift-Register Chain Reader

This block reads a daisy chain of one to four external 8-bit parallel-load, serial-out shift registers and returns their inputs as one parallel word. A single request starts a read. The controller first loads the parallel inputs into the chain. It then toggles a generated shift clock and collects one bit per rising edge, most significant bit first. At the end it presents the assembled word together with a one-cycle completion strobe.

The external register's shift/load control is driven by one output, `shld_o`. A high level means shift and a low level means load. The per-request mode input selects how that control behaves:
- **Pulse mode.** The line rests high and drops low briefly at the start of each read.
- **Select mode.** The line rests low, which keeps the parallel inputs flowing into the chain while idle, and goes high only for the length of the transfer.

The block is input-only. A write attempt raises an error strobe and leaves every pin as it was.

Top module: `sr_chain_reader`

## Requirements
- R1: A read issues exactly 8*NUM_BYTES rising edges of `sclk_o`, with NUM_BYTES between 1 and 4.
- R2: The first bit received lands in bit 8*NUM_BYTES-1 of `data_o` and the last bit received lands in bit 0. All bits of `data_o` above the chain length read zero.
- R3: With `sel_mode_i`=0 (pulse mode), `shld_o` rests at 1. After a request it goes to 0 for exactly LOAD_W clock cycles, then returns to 1 before the first `sclk_o` rise, and stays at 1 for the rest of the read.
- R4: With `sel_mode_i`=1 (select mode), `shld_o` rests at 0. It is 1 from the cycle after the request until the read ends, with no low pulse in between, and it returns to 0 after `done_o`.
- R5: `sclk_o` rests at 0. The first rise comes HALF_W cycles after `shld_o` settles high. Every high phase and every low phase between rises lasts HALF_W cycles. `sdata_i` is sampled at each rise.
- R6: `done_o` is a one-cycle pulse. `data_o` changes only in the cycle where `done_o` is high and otherwise holds its value.
- R7: `rd_req_i` is ignored while `busy_o` is high, so a read produces exactly one `done_o`, and `busy_o` falls together with `done_o`.
- R8: A high `wr_req_i` raises `err_o` for one cycle in the following cycle. It does not change `shld_o`, `sclk_o`, `busy_o` or the word being read.
- R9: After reset, `shld_o`=1, `sclk_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0 and `data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Start a read (taken when idle) |
| sel_mode_i | input | 1 | 0 = load pulse, 1 = select level |
| wr_req_i | input | 1 | Output write/set/clear/toggle attempt |
| sdata_i | input | 1 | Serial data from the chain |
| shld_o | output | 1 | Shift/load control: 1 shift, 0 load |
| sclk_o | output | 1 | Generated shift clock |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle read completion |
| err_o | output | 1 | One-cycle rejection of a write attempt |
| data_o | output | 32 | Assembled input word, right-justified |

## Verification
The bench models the external chain and reads patterns that expose byte order and edge bits, such as a single set MSB and LSB. A design that reverses bit order or drops the first bit would return a shifted or mirrored word.

It measures the load-pulse width and every shift-clock phase. It also checks that no shift edge appears while the line is in load. An off-by-one timer or a clock edge issued during load would show up as a wrong width or a corrupted first bit.

Select mode is checked for a resting low level and for picking up input changes made just before the request. A design stuck in pulse behaviour would miss those changes.

Requests held high during a transfer, and write attempts made while idle and while busy, must not add a second completion, a pin change or a corrupted word.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } st_e;
endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || hit_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sr_capture.sv
module sr_capture #(
  parameter int NBITS = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      smp_i,
  input  logic                      sd_i,
  input  logic                      commit_i,
  output logic [sr_pkg::WORD_W-1:0] word_o
);
  import sr_pkg::*;

  logic [NBITS-1:0]  acc_q;
  logic [WORD_W-1:0] acc_ext;
  logic [WORD_W-1:0] word_q;

  generate
    if (NBITS < WORD_W) begin : g_pad
      assign acc_ext = {{(WORD_W-NBITS){1'b0}}, acc_q};
    end else begin : g_full
      assign acc_ext = acc_q;
    end
  endgenerate

  // MSB-first: earliest bit ends up on top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (smp_i) acc_q <= {acc_q[NBITS-2:0], sd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (commit_i) word_q <= acc_ext;
  end

  assign word_o = word_q;
endmodule

// File: rtl/sr_chain_reader.sv
module sr_chain_reader #(
  parameter int NUM_BYTES = 4,
  parameter int LOAD_W    = 1,
  parameter int HALF_W    = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_req_i,
  input  logic        sel_mode_i,
  input  logic        wr_req_i,
  input  logic        sdata_i,
  output logic        shld_o,
  output logic        sclk_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] data_o
);
  import sr_pkg::*;

  localparam int NBITS = 8 * NUM_BYTES;
  localparam int MAXW  = (LOAD_W > HALF_W) ? LOAD_W : HALF_W;
  localparam int CW    = $clog2(MAXW + 1);
  localparam int BCW   = $clog2(NBITS + 1);

  st_e            st_q;
  logic           shld_q, sclk_q, done_q, err_q, mode_q;
  logic [BCW-1:0] bits_q;
  logic [CW-1:0]  lim;
  logic           hit, smp, commit, last_bit;

  assign lim      = (st_q == ST_LOAD) ? CW'(LOAD_W - 1) : CW'(HALF_W - 1);
  assign last_bit = (bits_q == BCW'(NBITS));
  assign smp      = hit && ((st_q == ST_SETUP) || (st_q == ST_LOW));
  assign commit   = hit && (st_q == ST_HIGH) && last_bit;

  sr_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == ST_IDLE),
    .lim_i  (lim),
    .hit_o  (hit)
  );

  sr_capture #(.NBITS(NBITS)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (smp),
    .sd_i     (sdata_i),
    .commit_i (commit),
    .word_o   (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      shld_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= 1'b0;
      bits_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= wr_req_i;  // input-only: every write is refused
      unique case (st_q)
        ST_IDLE: begin
          if (rd_req_i) begin
            mode_q <= sel_mode_i;
            bits_q <= '0;
            shld_q <= sel_mode_i;  // pulse: drop to load; select: go to shift
            st_q   <= sel_mode_i ? ST_SETUP : ST_LOAD;
          end else begin
            shld_q <= ~sel_mode_i;  // rest level per mode
          end
        end
        ST_LOAD: if (hit) begin
          shld_q <= 1'b1;
          st_q   <= ST_SETUP;
        end
        ST_SETUP: if (hit) begin
          sclk_q <= 1'b1;
          bits_q <= bits_q + 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (hit) begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            done_q <= 1'b1;
            shld_q <= ~mode_q;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_LOW;
          end
        end
        ST_LOW: if (hit) begin
          sclk_q <= 1'b1;
          bits_q <= bits_q + 1'b1;
          st_q   <= ST_HIGH;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign shld_o = shld_q;
  assign sclk_o = sclk_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  a_r1_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bits_q <= BCW'(NBITS)));
  a_r3_no_shift_in_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> shld_o);
  a_r5_sclk_rests_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> done_o);
  a_r7_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r8_err_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> err_o);
endmodule

// File: tb/sr_chain_reader_tb_top.sv
`timescale 1ns/1ps
module sr_chain_reader_tb_top;
  localparam int NB     = 3;
  localparam int LOAD_W = 2;
  localparam int HALF_W = 2;
  localparam int NBITS  = 8 * NB;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_req_i = 1'b0, sel_mode_i = 1'b0, wr_req_i = 1'b0;
  logic sdata_i;
  logic shld_o, sclk_o, busy_o, done_o, err_o;
  logic [31:0] data_o;

  always #10 clk_i = ~clk_i;

  sr_chain_reader #(.NUM_BYTES(NB), .LOAD_W(LOAD_W), .HALF_W(HALF_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_req_i(rd_req_i), .sel_mode_i(sel_mode_i),
    .wr_req_i(wr_req_i), .sdata_i(sdata_i), .shld_o(shld_o), .sclk_o(sclk_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .data_o(data_o)
  );

  // external chain model: load while shld low, shift after each sclk rise
  logic [NBITS-1:0] par_in = '0;
  logic [NBITS-1:0] chain = '0;
  logic sclk_prev = 1'b0;
  always @(posedge clk_i) begin
    sclk_prev <= sclk_o;
    if (!shld_o) chain <= par_in;
    else if (sclk_o && !sclk_prev) chain <= chain << 1;
  end
  assign sdata_i = chain[NBITS-1];

  int errors = 0, checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  int rises, bad_hi, bad_lo, lead, lead_cnt, shld_lo_cnt, rise_in_load, dones;
  int run_hi, run_lo;
  logic sclk_p = 1'b0;

  task automatic clr_stats();
    rises = 0; bad_hi = 0; bad_lo = 0; lead = -1; lead_cnt = 0;
    shld_lo_cnt = 0; rise_in_load = 0; dones = 0; run_hi = 0; run_lo = 0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) dones++;
      if (busy_o && !shld_o) shld_lo_cnt++;
      if (busy_o && shld_o && !sclk_o && rises == 0) lead_cnt++;
      if (sclk_o) begin
        if (!sclk_p) begin
          if (rises == 0) lead = lead_cnt;
          else if (run_lo != HALF_W) bad_lo++;
          rises++;
          if (!shld_o) rise_in_load++;
          run_hi = 1;
        end else run_hi++;
      end else begin
        if (sclk_p) begin
          if (run_hi != HALF_W) bad_hi++;
          run_lo = 1;
        end else run_lo++;
      end
      sclk_p = sclk_o;
    end
  end

  task automatic wait_done(output logic [31:0] got, output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (done_o) begin ok = 1; got = data_o; break; end
    end
  endtask

  task automatic t_reset();
    chk("R9", shld_o, 1, "shld after reset");
    chk("R9", sclk_o, 0, "sclk after reset");
    chk("R9", busy_o, 0, "busy after reset");
    chk("R9", {done_o, err_o}, 0, "strobes after reset");
    chk("R9", data_o, 0, "data after reset");
  endtask

  task automatic do_read(input logic mode, input logic [NBITS-1:0] val);
    logic [31:0] got, held;
    bit ok;
    @(negedge clk_i);
    sel_mode_i = mode;
    par_in = val;
    repeat (3) @(negedge clk_i);
    if (mode) chk("R4", shld_o, 0, "select rest level");
    else      chk("R3", shld_o, 1, "pulse rest level");
    chk("R5", sclk_o, 0, "sclk rest");
    clr_stats();
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    wait_done(got, ok);
    chk("R7", ok, 1, "read completes");
    chk("R2", got, {{(32-NBITS){1'b0}}, val}, "assembled word");
    chk("R1", rises, NBITS, "sclk rises");
    chk("R5", {bad_hi, bad_lo}, 0, "half-period widths");
    chk("R5", lead, HALF_W, "lead before first rise");
    chk("R3", rise_in_load, 0, "rise while loading");
    if (mode) chk("R4", shld_lo_cnt, 0, "shld low during select read");
    else      chk("R3", shld_lo_cnt, LOAD_W, "load pulse width");
    chk("R7", busy_o, 0, "busy drops with done");
    held = data_o;
    @(negedge clk_i);
    chk("R6", done_o, 0, "done single cycle");
    repeat (4) @(negedge clk_i);
    chk("R6", data_o, held, "word held");
    if (mode) chk("R4", shld_o, 0, "select returns low");
    else      chk("R3", shld_o, 1, "pulse returns high");
  endtask

  task automatic t_select_transparent();
    logic [31:0] got;
    bit ok;
    @(negedge clk_i);
    sel_mode_i = 1'b1;
    par_in = 24'h111111;
    repeat (3) @(negedge clk_i);
    par_in = 24'hC0FFEE;  // change just before request; latch is open in select mode
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    par_in = 24'h000000;  // shifting now, no effect
    wait_done(got, ok);
    chk("R4", got, 32'h00C0FFEE, "select captures latest inputs");
  endtask

  task automatic t_busy_ignore();
    logic [31:0] got;
    bit ok;
    @(negedge clk_i);
    sel_mode_i = 1'b0;
    par_in = 24'h3C96A5;
    repeat (2) @(negedge clk_i);
    clr_stats();
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rd_req_i = 1'b1;
    sel_mode_i = 1'b1;
    repeat (30) @(negedge clk_i);
    rd_req_i = 1'b0;
    sel_mode_i = 1'b0;
    wait_done(got, ok);
    chk("R7", got, 32'h003C96A5, "word with requests during busy");
    repeat (6) @(negedge clk_i);
    chk("R7", dones, 1, "single done");
    chk("R7", rises, NBITS, "no restarted shifting");
    chk("R7", busy_o, 0, "idle after read");
  endtask

  task automatic t_write_reject();
    logic [31:0] got;
    bit ok;
    logic sh0;
    @(negedge clk_i);
    sel_mode_i = 1'b0;
    repeat (2) @(negedge clk_i);
    sh0 = shld_o;
    wr_req_i = 1'b1;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk("R8", err_o, 1, "err after write");
    chk("R8", {shld_o, sclk_o, busy_o}, {sh0, 1'b0, 1'b0}, "pins after write");
    @(negedge clk_i);
    chk("R8", err_o, 0, "err single cycle");
    par_in = 24'h5A0F81;
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    repeat (30) @(negedge clk_i);
    wr_req_i = 1'b1;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk("R8", {err_o, busy_o}, 2'b11, "err during read");
    wait_done(got, ok);
    chk("R8", got, 32'h005A0F81, "word unaffected by write");
  endtask

  initial begin
    clr_stats();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    do_read(1'b0, 24'hA50F3C);
    do_read(1'b0, 24'h800001);
    do_read(1'b0, 24'hFFFFFF);
    do_read(1'b0, 24'h000000);
    do_read(1'b1, 24'h5A5A5A);
    do_read(1'b1, 24'h13579B);
    t_select_transparent();
    t_busy_ignore();
    t_write_reject();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule